// File: doc/BRIEF.md
# Idle State Eligibility Selector

This block decides which low-power idle state a processor should enter. It reads a small table of state descriptors that run from the shallowest state at index 0 to the deepest at the highest index. When it is given a predicted time until the next wake-up and a system wake-up latency limit, it returns the deepest state that is worth entering and that can still wake up fast enough. Each descriptor holds an entry latency, an exit latency and a break-even residency, all in microseconds. It also holds an optional explicit wake-up latency with a flag that marks the value as valid, and a disable flag.

A one-cycle start strobe begins a scan. The block samples the prediction and the limit on that strobe, then checks one table entry per clock. When the scan ends it presents the chosen index, a fallback flag and a done pulse in the same cycle. The basic wait-for-interrupt standby state is never stored in the table. It is reported through the fallback flag when no entry qualifies. Filling the table, predicting interrupts and carrying out the state entry all happen outside this block.

Top module: `idle_state_selector`

## Requirements
- R1: After reset, done_o, fallback_o and idx_o are all 0.
- R2: When a state's wake-present bit is 0, its effective wake-up latency is entry plus exit, computed at 33 bits so it never wraps. A sum above the limit rejects the state even when the low 32 bits of the sum are small.
- R3: When a state's wake-present bit is 1, its explicit wake-up latency replaces entry plus exit in the latency test.
- R4: A state qualifies only if the predicted residency is greater than or equal to its minimum residency. Equality qualifies.
- R5: A state whose disable bit is 1 is never selected. A disable bit of 0 means the state is operational.
- R6: A state whose effective wake-up latency is greater than the latency limit is rejected. Equality is accepted.
- R7: Among the qualifying states, the one with the highest index is returned on idx_o, with fallback_o at 0.
- R8: If no state qualifies, fallback_o is 1 and idx_o is 0, which selects the implicit standby state.
- R9: done_o is high for exactly one cycle, in the cycle after the N_STATES-th rising edge that follows the edge sampling start_i. idx_o and fallback_o change only in that cycle and hold their values at all other times.
- R10: A start_i that arrives while a scan is in progress is ignored. The prediction and the limit are taken only from the edge that starts the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Scan start strobe |
| predicted_us_i | input | 32 | Predicted time to next wake-up, in microseconds |
| lat_limit_us_i | input | 32 | System wake-up latency limit, in microseconds |
| entry_us_i | input | 32*N_STATES | Entry latency per state; state i is at [32*i +: 32] |
| exit_us_i | input | 32*N_STATES | Exit latency per state |
| min_res_us_i | input | 32*N_STATES | Break-even residency per state |
| wake_us_i | input | 32*N_STATES | Explicit wake-up latency per state |
| wake_present_i | input | N_STATES | 1: the explicit wake-up latency is valid |
| disabled_i | input | N_STATES | 1: the state is disabled |
| done_o | output | 1 | One-cycle result strobe |
| idx_o | output | IDX_W | Index of the selected state |
| fallback_o | output | 1 | 1: use the implicit standby state |

## Verification
Random tables with small latency values are combined with random predictions and limits. In each table the residency filter, the latency filter and the disable flags each reject some states, so a wrong index shows which filter made the mistake. Directed tables then probe the exact boundaries: prediction equal to the residency and one below it, and limit equal to the effective latency and one below it. Other directed tables use an entry-plus-exit sum that overflows 32 bits, an explicit wake-up latency that makes a state with large entry and exit latencies acceptable, and a disabled deepest state. These separate a wrong comparison direction, a wrapped sum and an ignored present flag. A second start strobe together with changed inputs in the middle of a scan shows whether the block re-samples its inputs when it should not.

// File: rtl/idle_sel_pkg.sv
package idle_sel_pkg;
  localparam int LAT_W = 32;
  typedef logic [LAT_W-1:0] lat_t;
  typedef logic [LAT_W:0]   lat_wide_t;

  typedef struct packed {
    lat_t entry_us;
    lat_t exit_us;
    lat_t min_res_us;
    lat_t wake_us;
    logic wake_present;
    logic disabled;
  } idle_desc_t;
endpackage

// File: rtl/idle_state_eval.sv
module idle_state_eval
  import idle_sel_pkg::*;
(
  input  idle_desc_t desc_i,
  input  lat_t       predicted_us_i,
  input  lat_t       lat_limit_us_i,
  output logic       eligible_o
);
  lat_wide_t eff_wake;
  logic      res_ok, lat_ok;

  always_comb begin
    if (desc_i.wake_present) eff_wake = {1'b0, desc_i.wake_us};
    else                     eff_wake = {1'b0, desc_i.entry_us} + {1'b0, desc_i.exit_us};
    res_ok     = predicted_us_i >= desc_i.min_res_us;
    lat_ok     = eff_wake <= {1'b0, lat_limit_us_i};
    eligible_o = !desc_i.disabled && res_ok && lat_ok;
  end
endmodule

// File: rtl/idle_scan_ctrl.sv
module idle_scan_ctrl #(
  parameter int N_STATES = 4,
  localparam int IDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STATES - 1);

  assign accept_o = start_i && !busy_o;
  assign last_o   = busy_o && (idx_o == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (last_o) busy_o <= 1'b0;
      else        idx_o  <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/idle_best_track.sv
module idle_best_track #(
  parameter int N_STATES = 4,
  localparam int IDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic             eligible_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             fallback_o
);
  logic             best_vld;
  logic [IDX_W-1:0] best_idx;

  // Ascending scan: a later hit is deeper and overwrites.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_vld <= 1'b0;
      best_idx <= '0;
    end else if (clear_i) begin
      best_vld <= 1'b0;
      best_idx <= '0;
    end else if (step_i && eligible_i) begin
      best_vld <= 1'b1;
      best_idx <= idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      idx_o      <= '0;
      fallback_o <= 1'b0;
    end else begin
      done_o <= last_i;
      if (last_i) begin
        if (eligible_i) begin
          idx_o      <= idx_i;
          fallback_o <= 1'b0;
        end else if (best_vld) begin
          idx_o      <= best_idx;
          fallback_o <= 1'b0;
        end else begin
          idx_o      <= '0;
          fallback_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/idle_state_selector.sv
module idle_state_selector
  import idle_sel_pkg::*;
#(
  parameter int N_STATES = 4,
  localparam int IDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int TBL_W   = LAT_W * N_STATES
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LAT_W-1:0]    predicted_us_i,
  input  logic [LAT_W-1:0]    lat_limit_us_i,
  input  logic [TBL_W-1:0]    entry_us_i,
  input  logic [TBL_W-1:0]    exit_us_i,
  input  logic [TBL_W-1:0]    min_res_us_i,
  input  logic [TBL_W-1:0]    wake_us_i,
  input  logic [N_STATES-1:0] wake_present_i,
  input  logic [N_STATES-1:0] disabled_i,
  output logic                done_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic                fallback_o
);
  idle_desc_t       tbl [N_STATES];
  idle_desc_t       cur_desc;
  lat_t             pred_q, limit_q;
  logic             accept, busy, last, eligible;
  logic [IDX_W-1:0] scan_idx;

  for (genvar g = 0; g < N_STATES; g++) begin : g_unpack
    assign tbl[g].entry_us     = entry_us_i[g*LAT_W +: LAT_W];
    assign tbl[g].exit_us      = exit_us_i[g*LAT_W +: LAT_W];
    assign tbl[g].min_res_us   = min_res_us_i[g*LAT_W +: LAT_W];
    assign tbl[g].wake_us      = wake_us_i[g*LAT_W +: LAT_W];
    assign tbl[g].wake_present = wake_present_i[g];
    assign tbl[g].disabled     = disabled_i[g];
  end

  assign cur_desc = tbl[scan_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q  <= '0;
      limit_q <= '0;
    end else if (accept) begin
      pred_q  <= predicted_us_i;
      limit_q <= lat_limit_us_i;
    end
  end

  idle_scan_ctrl #(.N_STATES(N_STATES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last),
    .idx_o    (scan_idx)
  );

  idle_state_eval u_eval (
    .desc_i         (cur_desc),
    .predicted_us_i (pred_q),
    .lat_limit_us_i (limit_q),
    .eligible_o     (eligible)
  );

  idle_best_track #(.N_STATES(N_STATES)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .step_i     (busy),
    .last_i     (last),
    .eligible_i (eligible),
    .idx_i      (scan_idx),
    .done_o     (done_o),
    .idx_o      (idx_o),
    .fallback_o (fallback_o)
  );
endmodule

// File: rtl/idle_state_selector_chk.sv
module idle_state_selector_chk #(
  parameter int N_STATES = 4,
  localparam int IDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [N_STATES-1:0] disabled_i,
  input logic                done_o,
  input logic [IDX_W-1:0]    idx_o,
  input logic                fallback_o
);
  logic             busy_c, end_c;
  logic [IDX_W-1:0] cnt_c;

  // Independent scan-window counter.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_c <= 1'b0;
      cnt_c  <= '0;
      end_c  <= 1'b0;
    end else begin
      end_c <= busy_c && (int'(cnt_c) == N_STATES - 1);
      if (!busy_c && start_i) begin
        busy_c <= 1'b1;
        cnt_c  <= '0;
      end else if (busy_c) begin
        if (int'(cnt_c) == N_STATES - 1) busy_c <= 1'b0;
        else                              cnt_c  <= cnt_c + 1'b1;
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_timing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == end_c);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(idx_o) && $stable(fallback_o)));
  p_fallback_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fallback_o |-> (idx_o == '0));
  p_sel_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fallback_o) |-> !disabled_i[idx_o]);
  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(idx_o) < N_STATES));
endmodule

bind idle_state_selector idle_state_selector_chk #(.N_STATES(N_STATES)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .disabled_i (disabled_i),
  .done_o     (done_o),
  .idx_o      (idx_o),
  .fallback_o (fallback_o)
);

// File: tb/idle_state_selector_tb_top.sv
module idle_state_selector_tb_top;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] pred = '0, lim = '0;
  logic [31:0] ent [N], ext [N], mr [N], wk [N];
  logic [N-1:0] wp, dis;
  logic [32*N-1:0] ent_f, ext_f, mr_f, wk_f;
  logic done;
  logic [IW-1:0] idx;
  logic fb;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_f[i*32 +: 32] = ent[i];
      ext_f[i*32 +: 32] = ext[i];
      mr_f[i*32 +: 32]  = mr[i];
      wk_f[i*32 +: 32]  = wk[i];
    end
  end

  idle_state_selector #(.N_STATES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .predicted_us_i(pred), .lat_limit_us_i(lim),
    .entry_us_i(ent_f), .exit_us_i(ext_f), .min_res_us_i(mr_f), .wake_us_i(wk_f),
    .wake_present_i(wp), .disabled_i(dis),
    .done_o(done), .idx_o(idx), .fallback_o(fb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Reference selection computed from the requirements.
  function automatic void ref_sel(input logic [31:0] p, input logic [31:0] l,
                                  output int e_idx, output bit e_fb);
    e_idx = 0;
    e_fb  = 1;
    for (int i = 0; i < N; i++) begin
      logic [32:0] eff;
      eff = wp[i] ? {1'b0, wk[i]} : ({1'b0, ent[i]} + {1'b0, ext[i]});
      if (!dis[i] && p >= mr[i] && eff <= {1'b0, l}) begin
        e_idx = i;
        e_fb  = 0;
      end
    end
  endfunction

  task automatic clear_table();
    for (int i = 0; i < N; i++) begin
      ent[i] = '0; ext[i] = '0; mr[i] = '0; wk[i] = '0;
    end
    wp = '0;
    dis = '1;
  endtask

  task automatic set_st(input int i, input logic [31:0] e, input logic [31:0] x,
                        input logic [31:0] m, input logic [31:0] w,
                        input bit p, input bit d);
    ent[i] = e; ext[i] = x; mr[i] = m; wk[i] = w; wp[i] = p; dis[i] = d;
  endtask

  task automatic run_scan(input logic [31:0] p, input logic [31:0] l,
                          input bit mid, input string req);
    int e_idx;
    bit e_fb;
    ref_sel(p, l, e_idx, e_fb);
    @(negedge clk);
    pred = p; lim = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R9", "done early", done, 0);
      if (mid && k == 1) begin
        start = 1'b1; pred = ~p; lim = '0;   // R10: must be ignored
      end else start = 1'b0;
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R9", "done at N edges", done, 1);
    chk(fb == e_fb, req, "fallback", fb, e_fb);
    chk(int'(idx) == e_idx, req, "idx", idx, e_idx);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", done, 0);
    chk(int'(idx) == e_idx && fb == e_fb, "R9", "hold after done", idx, e_idx);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7391));
    clear_table();
    repeat (3) @(negedge clk);
    chk(done == 0 && fb == 0 && idx == 0, "R1", "reset outputs", {done, fb, idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && fb == 0 && idx == 0, "R1", "after reset", {done, fb, idx}, 0);

    // R2: sum without explicit value, boundary and 33-bit wrap
    clear_table();
    set_st(0, 10, 20, 0, 0, 0, 0);
    run_scan(5, 30, 0, "R2");
    run_scan(5, 29, 0, "R2");
    set_st(0, 32'hFFFF_FFFF, 2, 0, 0, 0, 0);
    run_scan(5, 32'hFFFF_FFFF, 0, "R2");

    // R3: explicit value overrides the sum
    clear_table();
    set_st(1, 1000, 1000, 0, 5, 1, 0);
    run_scan(0, 5, 0, "R3");
    set_st(1, 1000, 1000, 0, 5, 0, 0);
    run_scan(0, 5, 0, "R3");

    // R4: residency boundary
    clear_table();
    set_st(2, 1, 1, 100, 0, 0, 0);
    run_scan(100, 50, 0, "R4");
    run_scan(99, 50, 0, "R4");

    // R6: limit boundary with explicit value
    clear_table();
    set_st(3, 0, 0, 0, 40, 1, 0);
    run_scan(10, 40, 0, "R6");
    run_scan(10, 39, 0, "R6");

    // R5 and R7: all eligible, then deepest disabled
    clear_table();
    for (int i = 0; i < N; i++) set_st(i, i, i, i * 10, 0, 0, 0);
    run_scan(1000, 1000, 0, "R7");
    dis[3] = 1'b1;
    run_scan(1000, 1000, 0, "R5");
    dis[2] = 1'b1; dis[0] = 1'b1;
    run_scan(1000, 1000, 0, "R5");

    // R8: nothing qualifies
    dis = '1;
    run_scan(1000, 1000, 0, "R8");

    // R10: restart and input change mid-scan ignored
    dis = '0;
    run_scan(15, 1000, 1, "R10");

    // Random mix (R7)
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++)
        set_st(i, $urandom % 200, $urandom % 200, $urandom % 400,
               $urandom % 300, $urandom % 2, ($urandom % 4) == 0);
      run_scan($urandom % 500, $urandom % 400, ($urandom % 8) == 0, "R7");
    end

    finish_run();
  end
endmodule